// File: doc/BRIEF.md
# Virtual Active-Priority Tracker with Non-Maskable Support

This block holds the record of which virtual interrupt priorities are currently being serviced for two interrupt groups (group 0 and group 1). Each group owns a bitmap of active priority levels, split into 32-bit words. An activation pulse takes an interrupt's priority, group and non-maskable flag and marks the corresponding level as active. An end-of-interrupt pulse retires the most urgent active entry. A direct write port lets software reload any active word, for example when a context is restored.

From this record the block produces the running priority: the most urgent level now in service. A separate readback word carries that value together with a non-maskable flag. When non-maskable support is built in, a non-maskable activation does not mark a priority level at all. Instead it sets one dedicated flag, and while that flag is set the running priority reads as the most urgent value, zero. The number of preemption bits sets how many levels are tracked: 5, 6 or 7 bits give 32, 64 or 128 levels per group.

Top module: `apt_tracker`

## Requirements
- R1: Synchronous active-high reset clears every active word of both groups and the non-maskable flag; afterwards run_prio reads 0xFF and rpr_word reads 0x00FF.
- R2: An activation marks level index act_prio >> (8 - PREEMPT_BITS) in the group chosen by act_grp (0 = group 0, 1 = group 1), so the low priority bits below the preemption field are ignored. The index is stored in word index/32 at bit index%32.
- R3: With the non-maskable flag clear, run_prio is the lowest level index set in the OR of both groups, shifted left by (8 - PREEMPT_BITS). It is 0xFF when no level is set.
- R4: With NMI_EN = 1, an activation with act_nmi = 1 sets only the non-maskable flag, whatever act_prio and act_grp are, and marks no level. While the flag is set, run_prio reads 0x00.
- R5: rpr_word[7:0] equals run_prio, rpr_word[15] mirrors the non-maskable flag, and rpr_word[14:8] is always zero.
- R6: An end-of-interrupt clears the non-maskable flag if it is set. Otherwise it clears the lowest set level index, in whichever groups hold it. With nothing active it has no effect.
- R7: A software write replaces the 32-bit word wr_word of group wr_grp with wr_data[31:0]. wr_data[32] loads the non-maskable flag only on a write to group 1 word 0 with NMI_EN = 1; on any other write it is ignored.
- R8: With NMI_EN = 0, act_nmi is ignored, so a non-maskable activation marks its level like any other, and wr_data[32] is ignored on every write.
- R9: When pulses coincide in one cycle, the write is applied first. The end-of-interrupt then clears the entry chosen from the state held before that cycle. The activation is applied last, so a level that is both cleared and set stays set.
- R10: run_prio and rpr_word are registered and take their new value at the clock edge that applies the pulse. A cycle with no pulse leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_valid | input | 1 | Activation pulse |
| act_prio | input | 8 | Priority of the interrupt being activated |
| act_grp | input | 1 | Group of the activation (0 or 1) |
| act_nmi | input | 1 | Activation is non-maskable |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| wr_en | input | 1 | Software write strobe for an active word |
| wr_grp | input | 1 | Group of the written word |
| wr_word | input | IDX_W | Index of the written word |
| wr_data | input | 33 | Bits 31:0 priority levels, bit 32 non-maskable flag |
| run_prio | output | 8 | Running priority |
| rpr_word | output | 16 | Readback: bits 7:0 priority, bit 15 non-maskable flag |

## Verification
Activation and end-of-interrupt can land in the same cycle, and a software write can join them. The table drives these pulses together in several cases. One case retires one level while a different level is marked. Another retires and re-marks the same level, where the result must keep the level set. A third clears a word by write while the same level is marked by activation and retired by end-of-interrupt. Each result is judged against the write-then-clear-then-set order after a single edge. The non-maskable flag is tested with a write that clears it while level bits in another group stay active, so that running priority zero and the flag can be told apart.

// File: rtl/apt_pkg.sv
package apt_pkg;
  localparam int PRIO_W      = 8;
  localparam int WORD_W      = 32;
  localparam int RPR_W       = 16;
  localparam int RPR_NMI_POS = 15;

  typedef logic [PRIO_W-1:0] prio_t;

  function automatic int words_for(input int preempt_bits);
    return 1 << (preempt_bits - 5);
  endfunction
endpackage

// File: rtl/apt_prio_enc.sv
module apt_prio_enc #(
  parameter int W  = 64,
  parameter int IW = 6
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/apt_word_bank.sv
module apt_word_bank #(
  parameter int NWORDS = 2,
  parameter int IDX_W  = 1,
  localparam int NBITS = NWORDS * apt_pkg::WORD_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_word,
  input  logic [apt_pkg::WORD_W-1:0] wr_data,
  input  logic [NBITS-1:0]           set_vec,
  input  logic [NBITS-1:0]           clr_vec,
  output logic [NBITS-1:0]           cur_vec,
  output logic [NBITS-1:0]           nxt_vec
);
  localparam int WW = apt_pkg::WORD_W;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WW-1:0] q;
    logic [WW-1:0] d;
    logic          hit;

    assign hit = wr_en && (wr_word == IDX_W'(w));
    assign d   = ((hit ? wr_data : q) & ~clr_vec[w*WW +: WW]) | set_vec[w*WW +: WW];

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end

    assign cur_vec[w*WW +: WW] = q;
    assign nxt_vec[w*WW +: WW] = d;
  end
endmodule

// File: rtl/apt_nmi_flag.sv
module apt_nmi_flag #(
  parameter int NMI_EN = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_en,
  input  logic wr_val,
  output logic cur,
  output logic nxt
);
  if (NMI_EN != 0) begin : g_on
    logic q;
    assign nxt = set_i | ((wr_en ? wr_val : q) & ~clr_i);
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= nxt;
    end
    assign cur = q;
  end else begin : g_off
    logic nmi_unused;
    assign nmi_unused = ^{clk, rst, set_i, clr_i, wr_en, wr_val};
    assign cur = 1'b0;
    assign nxt = 1'b0;
  end
endmodule

// File: rtl/apt_tracker.sv
module apt_tracker #(
  parameter int PREEMPT_BITS = 6,
  parameter int NMI_EN       = 1,
  localparam int NWORDS      = 1 << (PREEMPT_BITS - 5),
  localparam int IDX_W       = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act_valid,
  input  logic [7:0]        act_prio,
  input  logic              act_grp,
  input  logic              act_nmi,
  input  logic              eoi_valid,
  input  logic              wr_en,
  input  logic              wr_grp,
  input  logic [IDX_W-1:0]  wr_word,
  input  logic [32:0]       wr_data,
  output logic [7:0]        run_prio,
  output logic [15:0]       rpr_word
);
  import apt_pkg::*;

  localparam int NBITS = NWORDS * WORD_W;
  localparam int SHIFT = PRIO_W - PREEMPT_BITS;

  logic [PREEMPT_BITS-1:0] act_idx;
  logic                    act_is_nmi;
  logic [NBITS-1:0]        act_onehot;
  logic [NBITS-1:0]        set_g0, set_g1;
  logic [NBITS-1:0]        clr_vec;
  logic [NBITS-1:0]        g0_cur, g0_nxt, g1_cur, g1_nxt;
  logic                    nmi_cur, nmi_nxt;
  logic                    cur_found, nxt_found;
  logic [PREEMPT_BITS-1:0] cur_idx, nxt_idx;
  prio_t                   run_nxt;
  logic [RPR_W-1:0]        rpr_nxt;
  prio_t                   run_q;
  logic [RPR_W-1:0]        rpr_q;

  // Activation decode
  assign act_idx    = act_prio[PRIO_W-1:SHIFT];
  assign act_is_nmi = (NMI_EN != 0) && act_nmi;
  assign act_onehot = (act_valid && !act_is_nmi) ? (NBITS'(1) << act_idx) : '0;
  assign set_g0     = act_grp ? '0 : act_onehot;
  assign set_g1     = act_grp ? act_onehot : '0;

  // End-of-interrupt selection from the state held before this cycle
  apt_prio_enc #(.W(NBITS), .IW(PREEMPT_BITS)) u_enc_cur (
    .vec   (g0_cur | g1_cur),
    .found (cur_found),
    .idx   (cur_idx)
  );

  assign clr_vec = (eoi_valid && !nmi_cur && cur_found) ? (NBITS'(1) << cur_idx) : '0;

  apt_word_bank #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_bank_g0 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && !wr_grp),
    .wr_word (wr_word),
    .wr_data (wr_data[WORD_W-1:0]),
    .set_vec (set_g0),
    .clr_vec (clr_vec),
    .cur_vec (g0_cur),
    .nxt_vec (g0_nxt)
  );

  apt_word_bank #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_bank_g1 (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && wr_grp),
    .wr_word (wr_word),
    .wr_data (wr_data[WORD_W-1:0]),
    .set_vec (set_g1),
    .clr_vec (clr_vec),
    .cur_vec (g1_cur),
    .nxt_vec (g1_nxt)
  );

  apt_nmi_flag #(.NMI_EN(NMI_EN)) u_nmi (
    .clk    (clk),
    .rst    (rst),
    .set_i  (act_valid && act_is_nmi),
    .clr_i  (eoi_valid && nmi_cur),
    .wr_en  (wr_en && wr_grp && (wr_word == '0)),
    .wr_val (wr_data[WORD_W]),
    .cur    (nmi_cur),
    .nxt    (nmi_nxt)
  );

  // Running priority of the state after this edge
  apt_prio_enc #(.W(NBITS), .IW(PREEMPT_BITS)) u_enc_nxt (
    .vec   (g0_nxt | g1_nxt),
    .found (nxt_found),
    .idx   (nxt_idx)
  );

  always_comb begin
    if (nmi_nxt)        run_nxt = '0;
    else if (nxt_found) run_nxt = PRIO_W'(nxt_idx) << SHIFT;
    else                run_nxt = '1;
    rpr_nxt              = '0;
    rpr_nxt[PRIO_W-1:0]  = run_nxt;
    rpr_nxt[RPR_NMI_POS] = nmi_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '1;
      rpr_q <= RPR_W'(8'hFF);
    end else begin
      run_q <= run_nxt;
      rpr_q <= rpr_nxt;
    end
  end

  assign run_prio = run_q;
  assign rpr_word = rpr_q;
endmodule

// File: rtl/apt_tracker_chk.sv
module apt_tracker_chk #(
  parameter int PREEMPT_BITS = 6,
  parameter int NMI_EN       = 1
) (
  input logic        clk,
  input logic        rst,
  input logic        act_valid,
  input logic [7:0]  act_prio,
  input logic        act_nmi,
  input logic        eoi_valid,
  input logic        wr_en,
  input logic [7:0]  run_prio,
  input logic [15:0] rpr_word
);
  localparam logic [7:0] LVL_MASK = 8'hFF << (8 - PREEMPT_BITS);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (run_prio == 8'hFF && rpr_word == 16'h00FF));

  // R5
  rpr_layout_chk: assert property (@(posedge clk) disable iff (rst)
    (rpr_word[14:8] == 7'd0) && (rpr_word[7:0] == run_prio) && (!rpr_word[15] || run_prio == 8'h00));

  // R2
  act_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !act_nmi && !eoi_valid && !wr_en) |=> (run_prio <= ($past(act_prio) & LVL_MASK)));

  // R4
  nmi_set_chk: assert property (@(posedge clk) disable iff (rst)
    ((NMI_EN != 0) && act_valid && act_nmi && !wr_en) |=> rpr_word[15]);

  // R6
  nmi_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && rpr_word[15] && !act_valid && !wr_en) |=> !rpr_word[15]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_valid && !eoi_valid && !wr_en) |=> ($stable(run_prio) && $stable(rpr_word)));
endmodule

bind apt_tracker apt_tracker_chk #(.PREEMPT_BITS(PREEMPT_BITS), .NMI_EN(NMI_EN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .act_valid (act_valid),
  .act_prio  (act_prio),
  .act_nmi   (act_nmi),
  .eoi_valid (eoi_valid),
  .wr_en     (wr_en),
  .run_prio  (run_prio),
  .rpr_word  (rpr_word)
);

// File: tb/apt_tracker_test.sv
module apt_tracker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_valid = 0, act_grp = 0, act_nmi = 0, eoi_valid = 0;
  logic        wr_en = 0, wr_grp = 0;
  logic [0:0]  wr_word = '0;
  logic [7:0]  act_prio = '0;
  logic [32:0] wr_data = '0;
  logic [7:0]  run_a, run_b;
  logic [15:0] rpr_a, rpr_b;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  apt_tracker #(.PREEMPT_BITS(6), .NMI_EN(1)) uut (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_prio(act_prio), .act_grp(act_grp),
    .act_nmi(act_nmi), .eoi_valid(eoi_valid), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_word(wr_word), .wr_data(wr_data), .run_prio(run_a), .rpr_word(rpr_a));

  apt_tracker #(.PREEMPT_BITS(6), .NMI_EN(0)) uut_nonmi (
    .clk(clk), .rst(rst), .act_valid(act_valid), .act_prio(act_prio), .act_grp(act_grp),
    .act_nmi(act_nmi), .eoi_valid(eoi_valid), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_word(wr_word), .wr_data(wr_data), .run_prio(run_b), .rpr_word(rpr_b));

  typedef struct packed {
    logic        av;
    logic [7:0]  ap;
    logic        ag;
    logic        an;
    logic        eoi;
    logic        we;
    logic        wg;
    logic        ww;
    logic [32:0] wd;
    logic [7:0]  exp_run;
    logic [15:0] exp_rpr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'h40, 16'h0040, 8'd2}, // R2 g1 level 16
    '{1'b1, 8'h23, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'h20, 16'h0020, 8'd2}, // R2 low bits dropped
    '{1'b1, 8'h60, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'h20, 16'h0020, 8'd3}, // R3 lowest wins
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h40, 16'h0040, 8'd6}, // R6
    '{1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'h00, 16'h8000, 8'd4}, // R4
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h40, 16'h0040, 8'd6}, // R6 flag first
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h60, 16'h0060, 8'd6}, // R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'hFF, 16'h00FF, 8'd6}, // R6 empty
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'hFF, 16'h00FF, 8'd6}, // R6 no effect
    '{1'b1, 8'hFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'hFC, 16'h00FC, 8'd2}, // R2 word1 bit31
    '{1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'h00, 16'h0000, 8'd5}, // R5 zero without flag
    '{1'b1, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h80, 16'h0080, 8'd9}, // R9 clear 0 set 32
    '{1'b1, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h80, 16'h0080, 8'd9}, // R9 set wins
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'hFC, 16'h00FC, 8'd6}, // R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 33'h0,          8'hFF, 16'h00FF, 8'd7}, // R7
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 33'h1_0000_0010, 8'h00, 16'h8000, 8'd7}, // R7 flag load
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h10, 16'h0010, 8'd6}, // R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 33'h1_0000_0001, 8'h00, 16'h0000, 8'd7}, // R7 flag ignored g0
    '{1'b1, 8'h50, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 33'h0,          8'h00, 16'h8000, 8'd4}, // R4 any group
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 33'h0,          8'h00, 16'h0000, 8'd7}, // R7 flag cleared
    '{1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 33'h0_0000_0001, 8'h00, 16'h0000, 8'd9}, // R9 write+act
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'h08, 16'h0008, 8'd6}, // R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'hFF, 16'h00FF, 8'd6}, // R6
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 33'h0_8000_0000, 8'hFC, 16'h00FC, 8'd7}, // R7 g1 word1
    '{1'b1, 8'hFC, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 33'h0,          8'hFC, 16'h00FC, 8'd9}, // R9 all three
    '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 33'h0,          8'hFF, 16'h00FF, 8'd6}  // R6
  };

  task automatic check(input string tag, input logic [7:0] run, input logic [15:0] rpr,
                       input logic [7:0] erun, input logic [15:0] erpr);
    n_checks++;
    if (run !== erun || rpr !== erpr) begin
      n_fail++;
      $display("FAIL %s: run_prio=%h rpr_word=%h expected run_prio=%h rpr_word=%h",
               tag, run, rpr, erun, erpr);
    end
  endtask

  task automatic idle_inputs();
    act_valid = 0; act_prio = '0; act_grp = 0; act_nmi = 0;
    eoi_valid = 0; wr_en = 0; wr_grp = 0; wr_word = '0; wr_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected completion before 5000", cycles);
      finish_run();
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset uut", run_a, rpr_a, 8'hFF, 16'h00FF);
    check("R1 reset uut_nonmi", run_b, rpr_b, 8'hFF, 16'h00FF);

    for (int i = 0; i < NV; i++) begin
      act_valid = VECS[i].av;  act_prio = VECS[i].ap;  act_grp = VECS[i].ag;
      act_nmi   = VECS[i].an;  eoi_valid = VECS[i].eoi;
      wr_en     = VECS[i].we;  wr_grp   = VECS[i].wg;  wr_word = VECS[i].ww;
      wr_data   = VECS[i].wd;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), run_a, rpr_a,
            VECS[i].exp_run, VECS[i].exp_rpr);
    end
    idle_inputs();
    @(negedge clk);
    check("R10 idle hold", run_a, rpr_a, 8'hFF, 16'h00FF);

    // R1 reset in mid-operation
    act_valid = 1; act_prio = 8'h40; act_nmi = 1;
    @(negedge clk);
    idle_inputs();
    check("R4 flag before reset", run_a, rpr_a, 8'h00, 16'h8000);
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset clears flag", run_a, rpr_a, 8'hFF, 16'h00FF);
    check("R1 reset clears levels", run_b, rpr_b, 8'hFF, 16'h00FF);

    // R8 without non-maskable support
    act_valid = 1; act_prio = 8'h30; act_grp = 1; act_nmi = 1;
    @(negedge clk);
    idle_inputs();
    check("R8 nmi as level", run_b, rpr_b, 8'h30, 16'h0030);
    eoi_valid = 1;
    @(negedge clk);
    idle_inputs();
    check("R8 level retired", run_b, rpr_b, 8'hFF, 16'h00FF);
    wr_en = 1; wr_grp = 1; wr_word = '0; wr_data = 33'h1_0000_0000;
    @(negedge clk);
    idle_inputs();
    check("R8 flag bit dropped", run_b, rpr_b, 8'hFF, 16'h00FF);
    check("R7 flag bit loaded", run_a, rpr_a, 8'h00, 16'h8000);
    act_valid = 1; act_prio = 8'h00; act_nmi = 1;
    @(negedge clk);
    idle_inputs();
    check("R8 zero level no flag", run_b, rpr_b, 8'h00, 16'h0000);

    finish_run();
  end
endmodule